// File: doc/BRIEF.md
# Four-Lane Byte FIFO with Word and Byte Access

This block buffers data between a register interface and a serial shifter. Storage is four byte-wide FIFO lanes, 16 entries each by default. A 32-bit access pushes or pops one byte in every lane at once, so the word port can hold 64 bytes. An 8-bit access uses lane 0 alone, so the byte port holds only 16 bytes. On the serial side the block accepts and delivers single bytes. In word mode it walks the lanes in the order 0, 1, 2, 3, so the least significant byte of each word travels first. In byte mode it stays on lane 0.

A static `byte_mode` input tells the block which register port the current transfer uses. An access through the other port is refused and flagged as illegal. Seven sticky status bits report the fill level, data availability and illegal accesses. Software clears a bit by writing a 1 to its position on `status_clr`; the bit comes back at once if its condition still holds. A soft reset empties every lane and clears the status.

Top module: `qbf_fifo`

## Requirements
- R1: Byte k of a word written through the word port (bits 8k+7:8k, k = 0..3) goes into lane k, and a word read returns the lane heads in the same positions. Sixteen words (64 bytes) can be held and read back in order.
- R2: A word write while any lane holds 16 bytes is dropped, and the stored data stays unchanged.
- R3: The byte port writes and reads lane 0 only and holds at most 16 bytes; a 17th byte write is dropped. Lanes 1 to 3 are never touched in byte mode.
- R4: In word mode the serial output delivers bytes from lanes 0, 1, 2, 3 in turn. Serial input fills the lanes in the same turn, so four input bytes form one word with the first byte in bits 7:0.
- R5: In byte mode the serial side pushes to and pops from lane 0 only, in first-in first-out order.
- R6: A word read while some lanes are empty returns the bytes present, with zero in the empty lanes. It pops the lanes that hold data and sets the illegal bit.
- R7: Any access through the port that does not match `byte_mode` is dropped and sets the illegal bit. This covers a word write or word read in byte mode, and a byte write or byte read in word mode.
- R8: The status bits are: bit 0 full, bit 1 half, bit 2 empty, bit 3 low, bit 4 word-available, bit 5 byte-available, bit 6 illegal. In word mode the fill bits are computed over all lanes against 64 bytes: full means some lane is full, half means at least 32 bytes, low means at most 16 bytes. In byte mode they are computed over lane 0 against 16 bytes: full means 16, half means at least 8, low means at most 4. Empty means all lanes are empty. Word-available means every lane holds data. Byte-available means lane 0 holds data. Each bit is set one clock edge after its condition is present.
- R9: A status bit stays set after its condition ends, until a cycle in which `status_clr` has a 1 at that position. If the condition still holds during that cycle, the bit stays set.
- R10: A soft reset empties all lanes, returns both serial lane pointers to lane 0, and clears all status bits at the same clock edge.
- R11: Register access has priority over the serial side. `ser_in_ready` is low in any cycle with a register write, and `ser_out_valid` is low in any cycle with a register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Empties the lanes and clears the status |
| byte_mode | input | 1 | 1: the transfer uses the byte port; 0: the word port |
| wr_word_en | input | 1 | Word write strobe |
| wr_word_data | input | 32 | Word to write |
| wr_byte_en | input | 1 | Byte write strobe |
| wr_byte_data | input | 8 | Byte to write |
| rd_word_en | input | 1 | Word read strobe (pops) |
| rd_word_data | output | 32 | Lane heads, with zero in empty lanes |
| rd_byte_en | input | 1 | Byte read strobe (pops lane 0) |
| rd_byte_data | output | 8 | Lane 0 head, or zero when lane 0 is empty |
| ser_in_valid | input | 1 | Serial byte offered |
| ser_in_data | input | 8 | Serial byte in |
| ser_in_ready | output | 1 | Serial byte can be accepted |
| ser_out_valid | output | 1 | Serial byte available |
| ser_out_data | output | 8 | Serial byte out |
| ser_out_ready | input | 1 | Serial side takes the byte |
| status_clr | input | 7 | Write-one-to-clear mask for the status bits |
| status | output | 7 | Sticky status bits |

## Verification
The assertions assume that `byte_mode` is held steady while data is in flight, and that register strobes are single-cycle pulses driven clear of the clock edge. They do not assume that the serial side waits on the register side: overlap is allowed, and the priority rule resolves it. The stimulus changes `byte_mode` only right before a soft reset or with all lanes empty. Random operations are drawn from word writes, word reads, serial pushes and serial pops, and one operation is issued at a time. Directed sequences then overlap a register access with a serial request on purpose, to exercise the priority rule.

// File: rtl/qbf_pkg.sv
`timescale 1ns/1ps
package qbf_pkg;
    localparam int LANES  = 4;
    localparam int FLAG_W = 7;

    typedef enum logic {
        MODE_WORD = 1'b0,
        MODE_BYTE = 1'b1
    } mode_e;

    // bit 0 is the last member
    typedef struct packed {
        logic illegal;
        logic byte_av;
        logic word_av;
        logic low;
        logic empty;
        logic half;
        logic full;
    } flags_t;

    function automatic logic at_half(input int unsigned occ, input int unsigned cap);
        return (occ * 2) >= cap;
    endfunction

    function automatic logic at_low(input int unsigned occ, input int unsigned cap);
        return (occ * 4) <= cap;
    endfunction
endpackage

// File: rtl/qbf_bank.sv
`timescale 1ns/1ps
module qbf_bank #(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic             pop,
    output logic [7:0]       dout,
    output logic [CNT_W-1:0] count
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign do_push = push && (count != CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && count == CNT_W'(DEPTH)) |=> count == CNT_W'(DEPTH));
endmodule

// File: rtl/qbf_status.sv
`timescale 1ns/1ps
module qbf_status
    import qbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  flags_t            cond,
    input  logic [FLAG_W-1:0] clr,
    output flags_t            flags
);
    logic [FLAG_W-1:0] fv, cv;
    assign fv = flags;
    assign cv = cond;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) flags <= '0;
        else                 flags <= flags_t'((fv & ~clr) | cv);
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
        assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (fv[i] && !clr[i] && !soft_rst) |=> fv[i]);
        assert_cond_sets_R8: assert property (@(posedge clk) disable iff (rst)
            (cv[i] && !soft_rst) |=> fv[i]);
    end

    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> fv == '0);
endmodule

// File: rtl/qbf_fifo.sv
`timescale 1ns/1ps
module qbf_fifo
    import qbf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int WORD_W = 8 * LANES,
    localparam int LANE_W = $clog2(LANES),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              byte_mode,
    input  logic              wr_word_en,
    input  logic [WORD_W-1:0] wr_word_data,
    input  logic              wr_byte_en,
    input  logic [7:0]        wr_byte_data,
    input  logic              rd_word_en,
    output logic [WORD_W-1:0] rd_word_data,
    input  logic              rd_byte_en,
    output logic [7:0]        rd_byte_data,
    input  logic              ser_in_valid,
    input  logic [7:0]        ser_in_data,
    output logic              ser_in_ready,
    output logic              ser_out_valid,
    output logic [7:0]        ser_out_data,
    input  logic              ser_out_ready,
    input  logic [FLAG_W-1:0] status_clr,
    output logic [FLAG_W-1:0] status
);
    mode_e             mode;
    logic [CNT_W-1:0]  cnt [LANES];
    logic [7:0]        head [LANES];
    logic [LANES-1:0]  has_data, is_full;
    logic [LANE_W-1:0] in_lane_q, out_lane_q, in_lane, out_lane;
    logic              word_wr_ok, byte_wr_ok, word_rd_ok, byte_rd_ok;
    logic              ser_in_fire, ser_out_fire, illegal_ev;
    int unsigned       occ_now, cap_now;
    flags_t            cond, flags_q;

    assign mode     = mode_e'(byte_mode);
    assign in_lane  = (mode == MODE_BYTE) ? '0 : in_lane_q;
    assign out_lane = (mode == MODE_BYTE) ? '0 : out_lane_q;

    assign word_wr_ok = wr_word_en && mode == MODE_WORD && !(|is_full);
    assign byte_wr_ok = wr_byte_en && mode == MODE_BYTE && !is_full[0];
    assign word_rd_ok = rd_word_en && mode == MODE_WORD;
    assign byte_rd_ok = rd_byte_en && mode == MODE_BYTE && has_data[0];

    // register side wins over the serial side
    assign ser_in_ready  = !(wr_word_en || wr_byte_en) && !is_full[in_lane];
    assign ser_out_valid = !(rd_word_en || rd_byte_en) && has_data[out_lane];
    assign ser_out_data  = head[out_lane];
    assign ser_in_fire   = ser_in_valid && ser_in_ready;
    assign ser_out_fire  = ser_out_valid && ser_out_ready;
    assign rd_byte_data  = has_data[0] ? head[0] : 8'h00;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic       push, pop;
        logic [7:0] pdata;

        assign push = word_wr_ok || (byte_wr_ok && g == 0)
                   || (ser_in_fire && in_lane == LANE_W'(g));
        assign pop  = (word_rd_ok && has_data[g]) || (byte_rd_ok && g == 0)
                   || (ser_out_fire && out_lane == LANE_W'(g));
        assign pdata = word_wr_ok ? wr_word_data[8*g +: 8]
                     : (byte_wr_ok ? wr_byte_data : ser_in_data);

        qbf_bank #(.DEPTH(DEPTH)) u_bank (
            .clk(clk), .rst(rst), .flush(soft_rst),
            .push(push), .din(pdata), .pop(pop),
            .dout(head[g]), .count(cnt[g])
        );

        assign has_data[g] = cnt[g] != '0;
        assign is_full[g]  = cnt[g] == CNT_W'(DEPTH);
        assign rd_word_data[8*g +: 8] = has_data[g] ? head[g] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            in_lane_q  <= '0;
            out_lane_q <= '0;
        end else if (mode == MODE_WORD) begin
            if (ser_in_fire)  in_lane_q  <= in_lane_q + 1'b1;
            if (ser_out_fire) out_lane_q <= out_lane_q + 1'b1;
        end
    end

    assign illegal_ev = !soft_rst && (
           (wr_word_en && mode == MODE_BYTE)
        || (wr_byte_en && mode == MODE_WORD)
        || (rd_byte_en && mode == MODE_WORD)
        || (rd_word_en && (mode == MODE_BYTE || !(&has_data))));

    always_comb begin
        occ_now = 0;
        for (int i = 0; i < LANES; i++) occ_now += 32'(cnt[i]);
        cap_now = DEPTH * LANES;
        if (mode == MODE_BYTE) begin
            occ_now = 32'(cnt[0]);
            cap_now = DEPTH;
        end
        cond.full    = (mode == MODE_BYTE) ? is_full[0] : (|is_full);
        cond.half    = at_half(occ_now, cap_now);
        cond.low     = at_low(occ_now, cap_now);
        cond.empty   = has_data == '0;
        cond.word_av = &has_data;
        cond.byte_av = has_data[0];
        cond.illegal = illegal_ev;
    end

    qbf_status u_status (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .cond(cond), .clr(status_clr), .flags(flags_q)
    );
    assign status = flags_q;

    for (genvar g = 1; g < LANES; g++) begin : g_idle
        assert_byte_lanes_idle_R3: assert property (@(posedge clk) disable iff (rst)
            (byte_mode && !soft_rst) |=> $stable(cnt[g]));
    end

    assert_partial_read_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_word_en && !byte_mode && !soft_rst && !(&has_data)) |=> status[6]);

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (has_data == '0));
endmodule

// File: tb/tb_qbf_fifo.sv
`timescale 1ns/1ps
module tb_qbf_fifo;
    localparam logic [6:0] F_FULL = 7'h01, F_HALF = 7'h02, F_EMPTY = 7'h04, F_LOW = 7'h08,
                           F_WORD = 7'h10, F_BYTE = 7'h20, F_ILL = 7'h40;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, soft_rst = 1'b0, byte_mode = 1'b0;
    logic wr_word_en = 1'b0, wr_byte_en = 1'b0, rd_word_en = 1'b0, rd_byte_en = 1'b0;
    logic [31:0] wr_word_data = '0, rd_word_data;
    logic [7:0]  wr_byte_data = '0, rd_byte_data, ser_in_data = '0, ser_out_data;
    logic ser_in_valid = 1'b0, ser_in_ready, ser_out_valid, ser_out_ready = 1'b0;
    logic [6:0] status_clr = '0, status;

    qbf_fifo dut (.*);

    int nchk = 0, nfail = 0;

    // bench model of the four lanes
    logic [7:0] mm [4][16];
    int mh[4], mc[4];
    int wb, rb;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick; @(posedge clk); @(negedge clk); endtask
    task automatic wr_word(input logic [31:0] d);
        wr_word_en = 1; wr_word_data = d; tick(); wr_word_en = 0;
    endtask
    task automatic wr_byte(input logic [7:0] d);
        wr_byte_en = 1; wr_byte_data = d; tick(); wr_byte_en = 0;
    endtask
    task automatic rd_word(output logic [31:0] d);
        rd_word_en = 1; #1; d = rd_word_data; tick(); rd_word_en = 0;
    endtask
    task automatic rd_byte(output logic [7:0] d);
        rd_byte_en = 1; #1; d = rd_byte_data; tick(); rd_byte_en = 0;
    endtask
    task automatic ser_pop(output logic v, output logic [7:0] d);
        ser_out_ready = 1; #1; v = ser_out_valid; d = ser_out_data; tick(); ser_out_ready = 0;
    endtask
    task automatic ser_push(input logic [7:0] d, output logic r);
        ser_in_valid = 1; ser_in_data = d; #1; r = ser_in_ready; tick(); ser_in_valid = 0;
    endtask
    task automatic clr_all; status_clr = 7'h7f; tick(); status_clr = '0; endtask
    task automatic sreset; soft_rst = 1; tick(); soft_rst = 0; endtask

    function automatic logic [31:0] wval(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b + 8'hC0, b + 8'h80, b + 8'h40, b};
    endfunction

    task automatic summary;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [7:0]  b;
        logic        v, r;
        void'($urandom(32'd4242));
        @(negedge clk); tick(); tick();
        check("R10 status under reset", 32'(status), 32'h0);
        check("R11 no serial data under reset", 32'(ser_out_valid), 32'h0);
        rst = 0;
        tick();
        check("R8 status after reset", 32'(status), 32'(F_EMPTY | F_LOW));

        // R8 fill thresholds in word mode, R9 re-assertion on clear
        for (int i = 0; i < 4; i++) wr_word(wval(i));
        clr_all();
        check("R8 16 bytes", 32'(status), 32'(F_LOW | F_WORD | F_BYTE));
        for (int i = 4; i < 8; i++) wr_word(wval(i));
        clr_all();
        check("R8 32 bytes", 32'(status), 32'(F_HALF | F_WORD | F_BYTE));
        for (int i = 8; i < 16; i++) wr_word(wval(i));
        clr_all();
        check("R9 full re-asserts under clear", 32'(status), 32'(F_FULL | F_HALF | F_WORD | F_BYTE));
        // R2 dropped write
        wr_word(32'hDEADBEEF);
        for (int i = 0; i < 16; i++) begin
            rd_word(w);
            check("R1 word lanes in order", w, wval(i));
        end
        check("R2 extra word absent", 32'(status & F_ILL), 32'h0);
        check("R9 full still sticky", 32'(status & F_FULL), 32'(F_FULL));
        rd_word(w);
        check("R6 empty read data", w, 32'h0);
        check("R6 empty read illegal", 32'(status & F_ILL), 32'(F_ILL));
        clr_all();
        check("R9 cleared", 32'(status), 32'(F_EMPTY | F_LOW));

        // R6 partial read, R4 serial-in lane order
        sreset();
        ser_push(8'hA1, r); check("R4 serial in ready", 32'(r), 32'h1);
        ser_push(8'hB2, r);
        rd_word(w);
        check("R6 partial word", w, 32'h0000B2A1);
        check("R6 partial illegal", 32'(status & F_ILL), 32'(F_ILL));
        #1 check("R6 lanes popped", rd_word_data, 32'h0);
        sreset();
        ser_push(8'h01, r); ser_push(8'h02, r); ser_push(8'h03, r); ser_push(8'h04, r);
        rd_word(w);
        check("R4 serial bytes form word", w, 32'h04030201);
        check("R4 full word no illegal", 32'(status & F_ILL), 32'h0);

        // R4 serial out order
        sreset();
        wr_word(32'h44332211); wr_word(32'h88776655);
        for (int i = 0; i < 8; i++) begin
            ser_pop(v, b);
            check("R4 serial out valid", 32'(v), 32'h1);
            check("R4 serial out order", 32'(b), 32'((i + 1) * 8'h11));
        end
        ser_pop(v, b);
        check("R4 drained", 32'(v), 32'h0);

        // R11 priority
        sreset();
        wr_word_en = 1; wr_word_data = 32'h5A5A1234; ser_in_valid = 1; ser_in_data = 8'hEE;
        #1 check("R11 ser_in blocked by write", 32'(ser_in_ready), 32'h0);
        tick(); wr_word_en = 0; ser_in_valid = 0;
        rd_word_en = 1; ser_out_ready = 1;
        #1 check("R11 ser_out blocked by read", 32'(ser_out_valid), 32'h0);
        check("R11 word intact", rd_word_data, 32'h5A5A1234);
        tick(); rd_word_en = 0; ser_out_ready = 0;
        #1 check("R11 serial byte not stored", 32'(ser_out_valid), 32'h0);

        // byte mode: R3, R5, R7
        sreset(); byte_mode = 1;
        for (int i = 0; i < 17; i++) wr_byte(8'h50 + 8'(i));
        clr_all();
        check("R3 byte mode full", 32'(status), 32'(F_FULL | F_HALF | F_BYTE));
        wr_word(32'h99999999);
        check("R7 word write in byte mode", 32'(status & F_ILL), 32'(F_ILL));
        for (int i = 0; i < 16; i++) begin
            ser_pop(v, b);
            check("R5 byte mode serial order", {23'h0, v, b}, {23'h0, 1'b1, 8'h50 + 8'(i)});
        end
        ser_pop(v, b);
        check("R3 seventeenth byte dropped", 32'(v), 32'h0);
        wr_byte(8'h61); wr_byte(8'h62);
        rd_byte(b); check("R3 byte read lane 0", 32'(b), 32'h61);
        ser_push(8'h63, r);
        rd_byte(b); check("R5 byte fifo order", 32'(b), 32'h62);
        rd_byte(b); check("R5 serial into lane 0", 32'(b), 32'h63);
        sreset(); byte_mode = 0;
        tick();
        clr_all();
        wr_byte(8'h77);
        check("R7 byte write in word mode", 32'(status & F_ILL), 32'(F_ILL));
        #1 check("R7 byte write dropped", 32'(ser_out_valid), 32'h0);

        // R10 soft reset
        wr_word(32'h11111111); wr_word(32'h22222222);
        ser_pop(v, b); ser_push(8'h33, r);
        soft_rst = 1; tick(); soft_rst = 0;
        check("R10 status cleared", 32'(status), 32'h0);
        #1 check("R10 lanes empty", {31'h0, ser_out_valid}, 32'h0);
        check("R10 word port empty", rd_word_data, 32'h0);
        tick();
        check("R10 status after flush", 32'(status), 32'(F_EMPTY | F_LOW));
        wr_word(32'hCAFEF00D);
        ser_pop(v, b);
        check("R10 lane pointer back to 0", 32'(b), 32'h0D);

        // random mix in word mode
        sreset();
        for (int l = 0; l < 4; l++) begin mh[l] = 0; mc[l] = 0; end
        wb = 0; rb = 0;
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                logic [31:0] d;
                logic anyf;
                d = $urandom;
                anyf = 0;
                for (int l = 0; l < 4; l++) if (mc[l] == 16) anyf = 1;
                wr_word_en = 1; wr_word_data = d;
                #1 check("R11 random write blocks serial", 32'(ser_in_ready), 32'h0);
                tick(); wr_word_en = 0;
                if (!anyf) for (int l = 0; l < 4; l++) begin
                    mm[l][(mh[l] + mc[l]) % 16] = d[8*l +: 8]; mc[l]++;
                end
            end else if (op == 1) begin
                logic [31:0] e;
                for (int l = 0; l < 4; l++) e[8*l +: 8] = (mc[l] > 0) ? mm[l][mh[l]] : 8'h00;
                rd_word(w);
                check("R1 random word read", w, e);
                for (int l = 0; l < 4; l++) if (mc[l] > 0) begin mh[l] = (mh[l] + 1) % 16; mc[l]--; end
            end else if (op == 2) begin
                logic ev;
                ev = mc[rb] > 0;
                ser_pop(v, b);
                check("R4 random serial valid", 32'(v), 32'(ev));
                if (ev) begin
                    check("R4 random serial data", 32'(b), 32'(mm[rb][mh[rb]]));
                    mh[rb] = (mh[rb] + 1) % 16; mc[rb]--; rb = (rb + 1) % 4;
                end
            end else begin
                logic er;
                logic [7:0] d8;
                d8 = 8'($urandom);
                er = mc[wb] < 16;
                ser_push(d8, r);
                check("R4 random serial ready", 32'(r), 32'(er));
                if (er) begin
                    mm[wb][(mh[wb] + mc[wb]) % 16] = d8; mc[wb]++; wb = (wb + 1) % 4;
                end
            end
        end

        summary();
        $finish;
    end
endmodule